// File: doc/BRIEF.md
# Serial Clock Multiplier Programmer

This block reprograms an external clock synthesizer over a three-wire serial port: an enable line, a data line and a programming clock. A single start strobe hands it an 8-bit multiplier request. The block first pulls the request into a legal range. It then plays out the whole update without further help: a divisor frame, an idle gap, a multiplier frame, a second idle gap, and a go pulse. After that it keeps the programming clock running for a long burst so that the synthesizer can relock.

The programming clock comes from the system clock through a parameterized phase divider. Every serial pulse has three phases of equal length: a low setup phase, in which enable and data take their new values, then a high phase, then a low hold phase. While the update runs, `busy` is high. When the final burst pulse ends, `busy` falls and `done` pulses for one cycle.

Top module: `mulprog_top`

## Requirements
- R1: After reset, or when no update is running, `busy`, `done`, `prog_en`, `prog_dat` and `prog_clk` are all low. Asserting `rst_n` low during an update stops it, and all five outputs are low on the next cycle.
- R2: A start that arrives while idle is accepted, and `busy` is high on the next cycle. `busy` stays high for exactly 3·PHASE_CYCLES·(27+LOCK_PULSES) cycles. `done` is high for one cycle, namely the first cycle in which `busy` is low again.
- R3: A request below MIN_MULT−1 is replaced by MIN_MULT−1. A request above MAX_MULT−1 is replaced by MAX_MULT−1. Any other request is used as given. The defaults are MIN_MULT=13 and MAX_MULT=64, which gives the code range 12..63.
- R4: Serial pulses 0..9 form the divisor frame. Enable is high on all ten. Data is 1 on pulse 0 and 0 on pulse 1. Pulses 2..9 carry DIVISOR−1 least significant bit first; the default divisor of 6 sends 5.
- R5: Pulses 10..12 and 23..25 each form an idle gap, with enable low and data low.
- R6: Pulses 13..22 form the multiplier frame. Enable is high on all ten. Data is 1 on pulse 13 and 1 on pulse 14. Pulses 15..22 carry the clamped code least significant bit first.
- R7: Pulse 26 is the go command, a single pulse with enable high and data low.
- R8: Pulses 27 through 26+LOCK_PULSES form the lock burst, with enable and data low. LOCK_PULSES defaults to 51200. The update contains exactly 27+LOCK_PULSES pulses, and the programming clock then stays low.
- R9: Each pulse is a low setup phase, then a high phase, then a low hold phase, each lasting PHASE_CYCLES system cycles. Enable and data never change while the programming clock is high.
- R10: A start that arrives while `busy` is high is ignored. The update in progress keeps its code, its pulse count and its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe that starts an update |
| mult_req | input | 8 | Requested multiplier code, sampled with start |
| busy | output | 1 | High while an update runs |
| done | output | 1 | One-cycle pulse when the update finishes |
| prog_en | output | 1 | Serial enable to the synthesizer |
| prog_dat | output | 1 | Serial data to the synthesizer |
| prog_clk | output | 1 | Serial programming clock |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a running update. The code it carries would only show up in the multiplier frame, and only if the block wrongly latched it. The bench therefore starts an update, injects a start carrying a very different code about a hundred cycles in, and compares the recovered multiplier bits, the pulse count and the busy length with those of the first request. The bench also shrinks the lock burst through its parameter, which lets every pulse be decoded on each of the clamp vectors.

// File: rtl/mulprog_pkg.sv
// Shared types and frame layout for the serial clock multiplier programmer.
// Assumes an 8-bit payload per frame and a fixed order of frames.
package mulprog_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic en;
        logic dat;
    } pins_t;

    localparam int unsigned HDR_BITS     = 2;
    localparam int unsigned PAY_BITS     = 8;
    localparam int unsigned GAP_PULSES   = 3;
    localparam int unsigned FRAME_PULSES = HDR_BITS + PAY_BITS + GAP_PULSES;
    localparam int unsigned GO_IDX       = 2 * FRAME_PULSES;
    localparam int unsigned BURST_BASE   = GO_IDX + 1;

    // Enable/data levels for serial pulse number idx of an update.
    function automatic pins_t pulse_pins(input int unsigned idx,
                                         input logic [7:0] div_code,
                                         input logic [7:0] mul_code);
        pins_t       p;
        int unsigned off;
        logic        second;
        logic [7:0]  pay;
        p      = '0;
        second = (idx >= FRAME_PULSES);
        off    = second ? (idx - FRAME_PULSES) : idx;
        pay    = second ? mul_code : div_code;
        if (idx < GO_IDX) begin
            if (off == 0) begin
                p.en  = 1'b1;
                p.dat = 1'b1;
            end else if (off == 1) begin
                p.en  = 1'b1;
                p.dat = second;
            end else if (off < HDR_BITS + PAY_BITS) begin
                p.en  = 1'b1;
                p.dat = pay[3'(off - HDR_BITS)];
            end
        end else if (idx == GO_IDX) begin
            p.en  = 1'b1;
            p.dat = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/mulprog_clamp.sv
// Pulls a requested multiplier code into [MIN_CODE, MAX_CODE].
// Purely combinational; assumes MIN_CODE <= MAX_CODE.
module mulprog_clamp #(
    parameter int unsigned MIN_CODE = 12,
    parameter int unsigned MAX_CODE = 63
) (
    input  logic [7:0] req,
    output logic [7:0] code
);
    localparam logic [7:0] LO = 8'(MIN_CODE);
    localparam logic [7:0] HI = 8'(MAX_CODE);

    // Saturate the request at both range limits.
    always_comb begin
        if (req < LO)      code = LO;
        else if (req > HI) code = HI;
        else               code = req;
    end
endmodule

// File: rtl/mulprog_phase_gen.sv
// Emits a one-cycle tick every PHASE_CYCLES system cycles while run is high.
// The count restarts from zero whenever run is low.
module mulprog_phase_gen #(
    parameter int unsigned PHASE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Phase counter: counts while running, wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mulprog_seq.sv
// Walks the pulse sequence of one update: divisor frame, gap, multiplier
// frame, gap, go pulse, lock burst. Each pulse takes three phases of equal
// length: setup (clock low, new pins), high, and hold (clock low).
// Assumes tick comes from a divider that runs only while busy.
module mulprog_seq #(
    parameter logic [7:0]  DIV_CODE    = 8'd5,
    parameter int unsigned MIN_CODE    = 12,
    parameter int unsigned MAX_CODE    = 63,
    parameter int unsigned LOCK_PULSES = 51200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] mul_code,
    input  logic       tick,
    output logic       busy,
    output logic       done,
    output logic       prog_en,
    output logic       prog_dat,
    output logic       prog_clk
);
    import mulprog_pkg::*;

    localparam int unsigned TOTAL    = BURST_BASE + LOCK_PULSES;
    localparam int unsigned IDX_W    = $clog2(TOTAL + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [7:0]       mul_q;
    pins_t            nxt_pins;

    assign busy = (phase != PH_IDLE);

    // Pin levels for the pulse that follows the current one.
    always_comb nxt_pins = pulse_pins(32'(idx) + 1, DIV_CODE, mul_q);

    // Pulse sequencer: phase stepping, pulse index and output pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            idx      <= '0;
            mul_q    <= '0;
            prog_en  <= 1'b0;
            prog_dat <= 1'b0;
            prog_clk <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        mul_q                <= mul_code;
                        idx                  <= '0;
                        phase                <= PH_SETUP;
                        {prog_en, prog_dat}  <= pulse_pins(0, DIV_CODE, mul_code);
                    end
                end
                PH_SETUP: begin
                    if (tick) begin
                        prog_clk <= 1'b1;
                        phase    <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        prog_clk <= 1'b0;
                        phase    <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (tick) begin
                        if (idx == LAST_IDX) begin
                            phase    <= PH_IDLE;
                            prog_en  <= 1'b0;
                            prog_dat <= 1'b0;
                            done     <= 1'b1;
                        end else begin
                            idx                 <= idx + 1'b1;
                            {prog_en, prog_dat} <= nxt_pins;
                            phase               <= PH_SETUP;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: enable and data hold still while the programming clock is high.
    a_r9_pins_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_clk && $past(prog_clk)) |-> ($stable(prog_en) && $stable(prog_dat)));

    // R10: a start seen while busy leaves the latched code untouched.
    a_r10_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mul_q));

    // R3: the code in use always lies inside the legal range.
    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((mul_q >= 8'(MIN_CODE)) && (mul_q <= 8'(MAX_CODE))));

    // R1: the serial port is quiet whenever no update runs.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!prog_en && !prog_dat && !prog_clk));

    // R2: done marks the cycle in which busy has just fallen.
    a_r2_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: enable stays low through the lock burst.
    a_r8_burst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (32'(idx) >= BURST_BASE)) |-> !prog_en);
endmodule

// File: rtl/mulprog_top.sv
// Serial clock multiplier programmer: clamps the request, then drives one
// complete update sequence through a divided programming clock.
// Assumes DIVISOR-1 and MAX_MULT-1 each fit in eight bits.
module mulprog_top #(
    parameter int unsigned DIVISOR      = 6,
    parameter int unsigned MIN_MULT     = 13,
    parameter int unsigned MAX_MULT     = 64,
    parameter int unsigned PHASE_CYCLES = 2,
    parameter int unsigned LOCK_PULSES  = 51200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] mult_req,
    output logic       busy,
    output logic       done,
    output logic       prog_en,
    output logic       prog_dat,
    output logic       prog_clk
);
    localparam logic [7:0]  DIV_CODE = 8'(DIVISOR - 1);
    localparam int unsigned MIN_CODE = MIN_MULT - 1;
    localparam int unsigned MAX_CODE = MAX_MULT - 1;

    logic [7:0] code;
    logic       tick;

    mulprog_clamp #(
        .MIN_CODE (MIN_CODE),
        .MAX_CODE (MAX_CODE)
    ) u_clamp (
        .req  (mult_req),
        .code (code)
    );

    mulprog_phase_gen #(
        .PHASE_CYCLES (PHASE_CYCLES)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    mulprog_seq #(
        .DIV_CODE    (DIV_CODE),
        .MIN_CODE    (MIN_CODE),
        .MAX_CODE    (MAX_CODE),
        .LOCK_PULSES (LOCK_PULSES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mul_code (code),
        .tick     (tick),
        .busy     (busy),
        .done     (done),
        .prog_en  (prog_en),
        .prog_dat (prog_dat),
        .prog_clk (prog_clk)
    );
endmodule

// File: tb/tb_mulprog_top.sv
module tb_mulprog_top;
    localparam int PH     = 2;
    localparam int LOCK   = 20;
    localparam int NPULSE = 27 + LOCK;
    localparam int BUSYC  = 3 * PH * NPULSE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] mult_req = '0;
    logic       busy, done, prog_en, prog_dat, prog_clk;

    always #5 clk = ~clk;

    mulprog_top #(
        .DIVISOR (6), .MIN_MULT (13), .MAX_MULT (64),
        .PHASE_CYCLES (PH), .LOCK_PULSES (LOCK)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .mult_req (mult_req),
        .busy (busy), .done (done), .prog_en (prog_en),
        .prog_dat (prog_dat), .prog_clk (prog_clk)
    );

    // request -> expected clamped code
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {8'd0,   8'd12}, {8'd11,  8'd12}, {8'd12, 8'd12}, {8'd13, 8'd13},
        {8'd40,  8'd40}, {8'd63,  8'd63}, {8'd64, 8'd63}, {8'd255, 8'd63}
    };

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // monitor state
    logic cap_en [64];
    logic cap_d  [64];
    int   pulse_cnt, busy_len, done_cnt, done_bad, stab_err, hi_err, lo_err, burst_err;
    int   hi_cnt, lo_cnt;
    logic prev_clk, rise_en, rise_d;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mon_clear();
        pulse_cnt = 0; busy_len = 0; done_cnt = 0; done_bad = 0;
        stab_err = 0; hi_err = 0; lo_err = 0; burst_err = 0;
        hi_cnt = 0; lo_cnt = 0; prev_clk = 1'b0;
        for (int i = 0; i < 64; i++) begin cap_en[i] = 1'b0; cap_d[i] = 1'b0; end
    endtask

    // Watchdog and serial-port monitor, sampled away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
        if (rst_n) begin
            if (busy) busy_len++;
            if (done) begin done_cnt++; if (busy) done_bad++; end
            if (prog_clk && !prev_clk) begin
                if (pulse_cnt < 64) begin cap_en[pulse_cnt] = prog_en; cap_d[pulse_cnt] = prog_dat; end
                if (pulse_cnt >= 27 && (prog_en || prog_dat)) burst_err++;
                if (pulse_cnt > 0 && lo_cnt != 2 * PH) lo_err++;
                rise_en = prog_en; rise_d = prog_dat;
                pulse_cnt++; hi_cnt = 1;
            end else if (prog_clk) begin
                hi_cnt++;
                if (prog_en != rise_en || prog_dat != rise_d) stab_err++;
            end else if (!prog_clk && prev_clk) begin
                if (hi_cnt != PH) hi_err++;
                lo_cnt = 1;
            end else if (!prog_clk) begin
                lo_cnt++;
            end
            prev_clk = prog_clk;
        end
    end

    task automatic run_update(input logic [7:0] code, input bit inject, input logic [7:0] late);
        mon_clear();
        @(negedge clk);
        start = 1'b1; mult_req = code;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2", "busy after accepted start", busy, 1);
        for (int it = 0; it < 2000 && done_cnt == 0; it++) begin
            if (inject && it == 100) begin start = 1'b1; mult_req = late; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_frames(input logic [7:0] exp_code, input string tag);
        logic [9:0] div_act, mul_act, div_exp, mul_exp;
        int en_lo;
        en_lo = 0;
        for (int k = 0; k < 10; k++) begin
            div_act[k] = cap_d[k];
            mul_act[k] = cap_d[13 + k];
            if (!cap_en[k] || !cap_en[13 + k]) en_lo++;
        end
        div_exp = {8'd5, 1'b0, 1'b1};
        mul_exp = {exp_code, 1'b1, 1'b1};
        chk(div_act == div_exp, "R4", {tag, " divisor frame bits"}, div_act, div_exp);
        chk(mul_act == mul_exp, "R6", {tag, " multiplier frame bits"}, mul_act, mul_exp);
        chk(en_lo == 0, "R4", {tag, " enable low inside a frame"}, en_lo, 0);
        chk(!(cap_en[10] | cap_en[11] | cap_en[12] | cap_d[10] | cap_d[11] | cap_d[12] |
              cap_en[23] | cap_en[24] | cap_en[25] | cap_d[23] | cap_d[24] | cap_d[25]),
            "R5", {tag, " idle gaps quiet"}, 1, 0);
        chk(cap_en[26] == 1'b1 && cap_d[26] == 1'b0, "R7", {tag, " go pulse"},
            {cap_en[26], cap_d[26]}, 2);
        chk(pulse_cnt == NPULSE, "R8", {tag, " pulse count"}, pulse_cnt, NPULSE);
        chk(burst_err == 0, "R8", {tag, " burst pins"}, burst_err, 0);
        chk(busy_len == BUSYC, "R2", {tag, " busy length"}, busy_len, BUSYC);
        chk(done_cnt == 1 && done_bad == 0, "R2", {tag, " done pulse"}, done_cnt, 1);
        chk(stab_err == 0 && hi_err == 0 && lo_err == 0, "R9", {tag, " pulse shape"},
            stab_err + hi_err + lo_err, 0);
        chk(prog_clk == 1'b0 && busy == 1'b0, "R8", {tag, " clock parked low"}, prog_clk, 0);
    endtask

    initial begin
        mon_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, done, prog_en, prog_dat, prog_clk} == 5'b0, "R1", "outputs in reset",
            {busy, done, prog_en, prog_dat, prog_clk}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, prog_en, prog_dat, prog_clk} == 5'b0, "R1", "outputs idle after reset",
            {busy, done, prog_en, prog_dat, prog_clk}, 0);

        // R3: clamp vectors, each a full update
        for (int v = 0; v < NV; v++) begin
            run_update(VEC[v][15:8], 1'b0, 8'd0);
            check_frames(VEC[v][7:0], $sformatf("R3 req %0d", VEC[v][15:8]));
        end

        // R10: start while busy is ignored
        run_update(8'd40, 1'b1, 8'd200);
        check_frames(8'd40, "R10 late start");

        // R1: reset in the middle of an update
        mon_clear();
        @(negedge clk);
        start = 1'b1; mult_req = 8'd30;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, done, prog_en, prog_dat, prog_clk} == 5'b0, "R1", "outputs after mid-run reset",
            {busy, done, prog_en, prog_dat, prog_clk}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: a fresh update after the abort runs normally
        run_update(8'd20, 1'b0, 8'd0);
        check_frames(8'd20, "R2 after abort");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule